// File: doc/BRIEF.md
# Synchronous Burst Static RAM Core

This block is a single-port synchronous static RAM. Its address and control inputs are captured in registers, and a short burst counter walks through a group of four words. Every access is one cycle: a chip enable marks it, an address strobe starts a burst at a new address, and a burst-advance input moves to the next word. Writes use per-byte enables, or a global write that stores the whole word. A write finishes in the cycle after the command is captured, with no timed pulse on any input.

Two static configuration inputs set how reads behave. A flow-through select chooses whether read data leaves straight from the array in the cycle the command is captured, or passes through an output register and leaves one cycle later. A burst-order select chooses linear or interleaved ordering of the two low address bits. The data bus is not tri-stated here. A separate valid output stands for the bus drivers. It turns off as soon as a deselect is captured, one stage earlier than read data travels in pipelined mode. The output enable gates it without a clock.

Top module: `burst_sram`

## Requirements
- R1: While reset is high, and on the first cycle after reset is released with chip enable low, rd_valid is 0.
- R2: With lin_order=1, a burst loaded at address A with low bits s visits words whose low two bits are (s+k) mod 4 for k=0,1,2,3, one per advance. The upper address bits stay the same.
- R3: With lin_order=0, the burst visits low bits s XOR k for k=0,1,2,3. The upper address bits stay the same.
- R4: A captured cycle with ce=1 and both adr_stb and burst_adv low accesses the same word as the previous access. burst_adv with ce=0 does not move the burst counter.
- R5: With flow_mode=0, a read captured at clock edge k shows the word on rdata, with rd_valid=1, in the cycle right after edge k.
- R6: With flow_mode=1, a read captured at edge k shows its word on rdata, with rd_valid=1, in the cycle after edge k+1.
- R7: With flow_mode=1, when a deselect (ce=0) is captured at edge k+1 right after a read at edge k, rd_valid is 0 in the cycle after edge k+1.
- R8: In a write with glob_we=0, only the bytes whose byte_we bit is 1 change. Bit b of byte_we covers data bits [b*BYTE_W +: BYTE_W].
- R9: A write with glob_we=1 stores all bytes of wdata, whatever the value of byte_we.
- R10: With oe=0, rd_valid is 0 at once, without waiting for a clock edge.
- R11: A captured write cycle (glob_we=1 or any byte_we bit set) never sets rd_valid in the cycle after its capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the control pipeline |
| flow_mode | input | 1 | 0 = flow-through reads, 1 = pipelined reads (static) |
| lin_order | input | 1 | 1 = linear burst, 0 = interleaved burst (static) |
| ce | input | 1 | Chip enable; 0 captures a deselect |
| adr_stb | input | 1 | Loads addr and restarts the burst |
| burst_adv | input | 1 | Moves to the next burst word |
| addr | input | ADDR_W | Word address |
| byte_we | input | NBYTES | Per-byte write enables |
| glob_we | input | 1 | Writes every byte |
| wdata | input | NBYTES*BYTE_W | Write data, captured with the command |
| oe | input | 1 | Output enable, asynchronous gate on rd_valid |
| rdata | output | NBYTES*BYTE_W | Read data |
| rd_valid | output | 1 | Data bus drive enable |

## Verification
Every word is first filled with an arithmetic pattern using global writes while all byte enables are low. Then byte-enable writes with single lanes set change only one lane, so a lane mix-up gives a value that no other address holds. The read sweep starts a burst at every address, covering all four start offsets, in both burst orders and both latency modes. Linear and interleaved orders differ only for start offsets 1 and 3, and a wrong latency shows up as the neighbouring word's data. Short sequences of read then deselect, read then write, hold cycles, advance while disabled, and reads with the output enable low test the valid-signal timing apart from the data path.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int BURST_BITS = 2;

    typedef struct packed {
        logic act;
        logic wr;
    } cmd_t;

    function automatic logic [BURST_BITS-1:0] burst_lo(
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] cnt,
        input logic                  linear
    );
        return linear ? start + cnt : start ^ cnt;
    endfunction

endpackage

// File: rtl/bsr_addr_ctr.sv
module bsr_addr_ctr
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              adr_stb,
    input  logic              burst_adv,
    input  logic              lin_order,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] eff_addr
);
    logic [ADDR_W-1:0]     base_q;
    logic [BURST_BITS-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (ce) begin
            if (adr_stb) begin
                base_q <= addr;
                cnt_q  <= '0;
            end else if (burst_adv) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign eff_addr = {base_q[ADDR_W-1:BURST_BITS],
                       burst_lo(base_q[BURST_BITS-1:0], cnt_q, lin_order)};
endmodule

// File: rtl/bsr_array.sv
module bsr_array #(
    parameter int ADDR_W = 8,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [NBYTES-1:0]        be,
    input  logic [ADDR_W-1:0]        adr,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    output logic [NBYTES*BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane [DEPTH];

        always_ff @(posedge clk) begin
            if (we && be[b]) lane[adr] <= wdata[b*BYTE_W +: BYTE_W];
        end

        assign rdata[b*BYTE_W +: BYTE_W] = lane[adr];
    end
endmodule

// File: rtl/bsr_out_stage.sv
module bsr_out_stage #(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flow_mode,
    input  logic              oe,
    input  logic              cur_act,
    input  logic              cur_wr,
    input  logic [WORD_W-1:0] arr_data,
    output logic [WORD_W-1:0] rdata,
    output logic              rd_valid
);
    logic              pipe_rd_q;
    logic [WORD_W-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_rd_q <= 1'b0;
        else     pipe_rd_q <= cur_act & ~cur_wr;
    end

    always_ff @(posedge clk) begin
        pipe_q <= arr_data;
    end

    assign rdata    = flow_mode ? pipe_q : arr_data;
    // Drive enable drops as soon as a deselect or write is captured.
    assign rd_valid = oe & cur_act & ~cur_wr & (~flow_mode | pipe_rd_q);
endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flow_mode,
    input  logic                     lin_order,
    input  logic                     ce,
    input  logic                     adr_stb,
    input  logic                     burst_adv,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES-1:0]        byte_we,
    input  logic                     glob_we,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    input  logic                     oe,
    output logic [NBYTES*BYTE_W-1:0] rdata,
    output logic                     rd_valid
);
    localparam int WORD_W = NBYTES * BYTE_W;

    cmd_t              cur_q;
    logic [NBYTES-1:0] be_q;
    logic [WORD_W-1:0] wd_q;
    logic [ADDR_W-1:0] eff_addr;
    logic [WORD_W-1:0] arr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{act: 1'b0, wr: 1'b0};
        end else begin
            cur_q.act <= ce;
            cur_q.wr  <= ce & (glob_we | (|byte_we));
        end
    end

    always_ff @(posedge clk) begin
        be_q <= glob_we ? {NBYTES{1'b1}} : byte_we;
        wd_q <= wdata;
    end

    bsr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .ce        (ce),
        .adr_stb   (adr_stb),
        .burst_adv (burst_adv),
        .lin_order (lin_order),
        .addr      (addr),
        .eff_addr  (eff_addr)
    );

    bsr_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_arr (
        .clk   (clk),
        .we    (cur_q.act & cur_q.wr),
        .be    (be_q),
        .adr   (eff_addr),
        .wdata (wd_q),
        .rdata (arr_data)
    );

    bsr_out_stage #(.WORD_W(WORD_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .flow_mode (flow_mode),
        .oe        (oe),
        .cur_act   (cur_q.act),
        .cur_wr    (cur_q.wr),
        .arr_data  (arr_data),
        .rdata     (rdata),
        .rd_valid  (rd_valid)
    );
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
    parameter int NBYTES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              flow_mode,
    input logic              ce,
    input logic [NBYTES-1:0] byte_we,
    input logic              glob_we,
    input logic              oe,
    input logic              rd_valid
);
    // R1
    rst_quiet_chk: assert property (@(posedge clk) rst |=> !rd_valid);

    // R10
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !oe |-> !rd_valid);

    // R11
    write_silent_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ce && (glob_we || (|byte_we))) |-> !rd_valid);

    // R7
    deselect_fast_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(ce) |-> !rd_valid);

    // R5
    flow_src_chk: assert property (@(posedge clk) disable iff (rst)
        (!flow_mode && rd_valid) |-> $past(ce && !glob_we && (byte_we == '0)));

    // R6
    pipe_src_chk: assert property (@(posedge clk) disable iff (rst)
        (flow_mode && rd_valid) |-> $past(ce && !glob_we && (byte_we == '0), 2));
endmodule

bind burst_sram burst_sram_chk #(.NBYTES(NBYTES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .flow_mode (flow_mode),
    .ce        (ce),
    .byte_we   (byte_we),
    .glob_we   (glob_we),
    .oe        (oe),
    .rd_valid  (rd_valid)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;
    localparam int AW = 8;
    localparam int NB = 2;
    localparam int BW = 9;
    localparam int W  = NB * BW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst, flow_mode, lin_order, ce, adr_stb, burst_adv, glob_we, oe;
    logic [AW-1:0] addr;
    logic [NB-1:0] byte_we;
    logic [W-1:0]  wdata, rdata;
    logic          rd_valid;

    burst_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) uut (
        .clk(clk), .rst(rst), .flow_mode(flow_mode), .lin_order(lin_order),
        .ce(ce), .adr_stb(adr_stb), .burst_adv(burst_adv), .addr(addr),
        .byte_we(byte_we), .glob_we(glob_we), .wdata(wdata), .oe(oe),
        .rdata(rdata), .rd_valid(rd_valid)
    );

    int errs = 0;
    int checks = 0;

    logic [W-1:0]  mdl [1<<AW];
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic          c_act = 1'b0, c_wr = 1'b0, p_rd = 1'b0;
    logic [AW-1:0] c_addr = '0, p_addr = '0;
    logic [NB-1:0] c_be = '0;
    logic [W-1:0]  c_wd = '0;

    function automatic logic [W-1:0] pat(input int a);
        return W'(a * 263 + 17);
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input string tag, input logic c, input logic s, input logic av,
                       input logic [AW-1:0] a, input logic [NB-1:0] be, input logic g,
                       input logic [W-1:0] d, input logic o);
        logic ev;
        @(negedge clk);
        ce = c; adr_stb = s; burst_adv = av; addr = a;
        byte_we = be; glob_we = g; wdata = d; oe = o;
        @(posedge clk);
        if (c_act && c_wr)
            for (int b = 0; b < NB; b++)
                if (c_be[b]) mdl[c_addr][b*BW +: BW] = c_wd[b*BW +: BW];
        p_rd   = c_act & ~c_wr;
        p_addr = c_addr;
        if (c) begin
            if (s) begin m_base = a; m_cnt = 2'd0; end
            else if (av) m_cnt = m_cnt + 2'd1;
        end
        c_act = c;
        c_wr  = c & (g | (|be));
        c_be  = g ? {NB{1'b1}} : be;
        c_wd  = d;
        c_addr = {m_base[AW-1:2], lin_order ? m_base[1:0] + m_cnt : m_base[1:0] ^ m_cnt};
        #1;
        ev = o & c_act & ~c_wr & (~flow_mode | p_rd);
        check({tag, " valid"}, W'(rd_valid), W'(ev));
        if (ev) check({tag, " data"}, rdata, flow_mode ? mdl[p_addr] : mdl[c_addr]);
    endtask

    task automatic idle();
        cyc("R7", 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b1);
    endtask

    initial begin
        #(8 * 200000);
        errs++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; flow_mode = 1'b0; lin_order = 1'b1; ce = 1'b0; adr_stb = 1'b0;
        burst_adv = 1'b0; addr = '0; byte_we = '0; glob_we = 1'b0; wdata = '0; oe = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", W'(rd_valid), '0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check("R1 after reset", W'(rd_valid), '0);

        // R9: global write with all byte enables low
        for (int a = 0; a < (1 << AW); a++)
            cyc("R9", 1'b1, 1'b1, 1'b0, AW'(a), 2'b00, 1'b1, pat(a), 1'b1);
        idle();

        // R8: single-lane writes
        for (int a = 0; a < (1 << AW); a += 5)
            cyc("R8", 1'b1, 1'b1, 1'b0, AW'(a), 2'b10, 1'b0, ~pat(a), 1'b1);
        for (int a = 1; a < (1 << AW); a += 7)
            cyc("R8", 1'b1, 1'b1, 1'b0, AW'(a), 2'b01, 1'b0, ~pat(a + 3), 1'b1);
        idle();

        // R2 R3 R5 R6: every start address, both orders, both latencies
        for (int fm = 0; fm < 2; fm++) begin
            for (int lo = 0; lo < 2; lo++) begin
                idle();
                @(negedge clk); flow_mode = fm[0]; lin_order = lo[0];
                for (int g = 0; g < 64; g++) begin
                    for (int s = 0; s < 4; s++) begin
                        string t;
                        t = $sformatf("%s %s", lo ? "R2" : "R3", fm ? "R6" : "R5");
                        cyc(t, 1'b1, 1'b1, 1'b0, AW'(g * 4 + s), '0, 1'b0, '0, 1'b1);
                        for (int k = 0; k < 3; k++)
                            cyc(t, 1'b1, 1'b0, 1'b1, '0, '0, 1'b0, '0, 1'b1);
                    end
                end
                idle();
            end
        end

        for (int fm = 0; fm < 2; fm++) begin
            idle();
            @(negedge clk); flow_mode = fm[0]; lin_order = 1'b1;
            // R4: hold and disabled advance
            cyc("R4", 1'b1, 1'b1, 1'b0, 8'h21, '0, 1'b0, '0, 1'b1);
            cyc("R4", 1'b1, 1'b0, 1'b0, 8'h00, '0, 1'b0, '0, 1'b1);
            cyc("R4", 1'b1, 1'b0, 1'b0, 8'h00, '0, 1'b0, '0, 1'b1);
            cyc("R4", 1'b0, 1'b0, 1'b1, 8'h00, '0, 1'b0, '0, 1'b1);
            cyc("R4", 1'b1, 1'b0, 1'b0, 8'h00, '0, 1'b0, '0, 1'b1);
            cyc("R4", 1'b1, 1'b0, 1'b1, 8'h00, '0, 1'b0, '0, 1'b1);
            // R7: read then deselect
            cyc("R7", 1'b1, 1'b1, 1'b0, 8'h40, '0, 1'b0, '0, 1'b1);
            cyc("R7", 1'b0, 1'b0, 1'b0, 8'h00, '0, 1'b0, '0, 1'b1);
            cyc("R7", 1'b1, 1'b1, 1'b0, 8'h41, '0, 1'b0, '0, 1'b1);
            cyc("R7", 1'b1, 1'b0, 1'b1, 8'h00, '0, 1'b0, '0, 1'b1);
            // R10: output enable low
            cyc("R10", 1'b1, 1'b0, 1'b1, 8'h00, '0, 1'b0, '0, 1'b0);
            cyc("R10", 1'b1, 1'b0, 1'b1, 8'h00, '0, 1'b0, '0, 1'b0);
            cyc("R10", 1'b1, 1'b0, 1'b0, 8'h00, '0, 1'b0, '0, 1'b1);
            // R11: read then write, then read back
            cyc("R11", 1'b1, 1'b1, 1'b0, 8'h90, '0, 1'b0, '0, 1'b1);
            cyc("R11", 1'b1, 1'b1, 1'b0, 8'h91, 2'b11, 1'b0, 18'h2A5A5 + W'(fm), 1'b1);
            cyc("R11", 1'b1, 1'b1, 1'b0, 8'h91, '0, 1'b0, '0, 1'b1);
            cyc("R11", 1'b1, 1'b0, 1'b0, 8'h00, '0, 1'b0, '0, 1'b1);
            idle();
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule